// File: doc/BRIEF.md
# Software-Managed Translation Buffer Search Unit

This block holds the tag half of a 64-entry, fully associative translation buffer for a small embedded core whose page tables are kept by software. Software loads an entry by presenting an index and a 32-bit tag word. The unit works out the page mask from the size code in that word, stores the masked page number and the valid flag, and records the process ID that is current at that moment. A tag word that asks for a little-endian page is refused, and an error flag is raised.

The search port takes a virtual address. All entries are compared in parallel against it and against the current process ID. One cycle later the unit returns the lowest-numbered matching index, or all ones when nothing matches. It also returns a 4-bit condition field for the recording form of the search instruction. An entry whose stored process ID is zero is global and matches any process.

Top module: `tlb_search_unit`

## Requirements
- R1: After reset every entry is invalid, so any search misses. While reset is held and on the first cycle after it, `res_valid` and `wr_err` are 0.
- R2: A tag write whose bit 6 is 0 leaves the target entry invalid. An invalid entry never matches a search.
- R3: An entry whose stored process ID is 0 matches whatever the current process ID is. Any other entry matches only when its stored ID equals `cur_pid` in the cycle of the search.
- R4: Tag bits 9:7 hold a size code n, and the page size is 1 KiB × 4^n. The stored page number is the tag ANDed with 0xFFFFFC00 and with the page mask. A search hits an entry when the address ANDed with that entry's mask equals the stored page number.
- R5: When several entries match, the result is the lowest index among them.
- R6: When no entry matches, `res_idx` is 0xFFFFFFFF. On a hit, `res_idx` holds the index zero-extended to 32 bits.
- R7: `res_cr` bit 0 equals `so_bit` in the cycle of the search, and bit 1 is 1 exactly on a hit. Bits 3:2 are 0.
- R8: A search requested in cycle k gives `res_valid`=1 with its results in cycle k+1. `res_valid` is 0 in any cycle whose previous cycle had no request.
- R9: A tag write with bit 5 set (little-endian page) is rejected and the target entry is left unchanged. `wr_err` is 1 in the next cycle, and `wr_err` is 1 at no other time.
- R10: The process ID is latched at write time. Changing `cur_pid` later does not change the ID stored in the entry.
- R11: When a write and a search fall in the same cycle, the search sees the contents from before the write. The write is visible to searches from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Tag write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 32 | Tag word: page number, size code, valid, endian, attributes |
| cur_pid | input | 8 | Current process ID register |
| so_bit | input | 1 | Summary-overflow bit copied into the condition field |
| srch_en | input | 1 | Search request |
| srch_va | input | 32 | Virtual address to look up |
| res_valid | output | 1 | Search result valid (one cycle after the request) |
| res_idx | output | 32 | Matching index, or all ones on a miss |
| res_cr | output | 4 | Condition field: bit1 hit, bit0 summary overflow |
| wr_err | output | 1 | Previous write was rejected as little-endian |

## Verification
The two functions that can fall in the same cycle are a tag write and a search, and they may target the same entry. The bench provokes this with a directed case in which a write creates the only entry that would match, issued in the same cycle as a search for its address. It also issues writes and searches together on most random cycles, drawing addresses from a small shared pool so that they collide often. For each such cycle the bench model works out the expected search result from its table before it applies the write. A result that reflects the new entry therefore counts as a failure, and the next search must then see the new entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W      = 32;
  localparam int MIN_SHIFT = 10;
  localparam logic [VA_W-1:0] EPN_KEEP = 32'hFFFF_FC00;

  // tag word field positions
  localparam int TAG_SIZE_LO = 7;
  localparam int TAG_VALID   = 6;
  localparam int TAG_LE      = 5;

  // page size is 2^(10 + 2*code); mask keeps the bits above it
  function automatic logic [VA_W-1:0] page_mask(input logic [2:0] code);
    int sh;
    sh = MIN_SHIFT + 2 * int'(code);
    return ~((VA_W'(1) << sh) - VA_W'(1));
  endfunction

  function automatic logic [VA_W-1:0] epn_of(input logic [VA_W-1:0] tag,
                                             input logic [VA_W-1:0] mask);
    return tag & EPN_KEEP & mask;
  endfunction

  function automatic logic [2:0] size_code(input logic [VA_W-1:0] tag);
    return tag[TAG_SIZE_LO +: 3];
  endfunction
endpackage

// File: rtl/tlb_entry_bank.sv
module tlb_entry_bank
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [VA_W-1:0]                 wr_tag,
  input  logic [PID_W-1:0]                cur_pid,
  output logic [ENTRIES-1:0]              ent_valid,
  output logic [ENTRIES-1:0][VA_W-1:0]    ent_epn,
  output logic [ENTRIES-1:0][VA_W-1:0]    ent_mask,
  output logic [ENTRIES-1:0][PID_W-1:0]   ent_pid,
  output logic                            wr_reject
);
  logic            wr_ok;
  logic [VA_W-1:0] new_mask;

  assign wr_reject = wr_en & wr_tag[TAG_LE];
  assign wr_ok     = wr_en & ~wr_tag[TAG_LE];
  assign new_mask  = page_mask(size_code(wr_tag));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[i] <= 1'b0;
        ent_epn[i]   <= '0;
        ent_mask[i]  <= '1;
        ent_pid[i]   <= '0;
      end else if (wr_ok && wr_idx == IDX_W'(i)) begin
        ent_valid[i] <= wr_tag[TAG_VALID];
        ent_epn[i]   <= epn_of(wr_tag, new_mask);
        ent_mask[i]  <= new_mask;
        ent_pid[i]   <= cur_pid;
      end
    end
  end
endmodule

// File: rtl/tlb_match_vec.sv
module tlb_match_vec
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PID_W   = 8
) (
  input  logic [ENTRIES-1:0]            ent_valid,
  input  logic [ENTRIES-1:0][VA_W-1:0]  ent_epn,
  input  logic [ENTRIES-1:0][VA_W-1:0]  ent_mask,
  input  logic [ENTRIES-1:0][PID_W-1:0] ent_pid,
  input  logic [VA_W-1:0]               va,
  input  logic [PID_W-1:0]              pid,
  output logic [ENTRIES-1:0]            hit_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic pid_ok, addr_ok;
    assign pid_ok     = (ent_pid[i] == '0) || (ent_pid[i] == pid);
    assign addr_ok    = (va & ent_mask[i]) == ent_epn[i];
    assign hit_vec[i] = ent_valid[i] & pid_ok & addr_ok;
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   first
);
  always_comb begin
    any   = 1'b0;
    first = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) begin
        any   = 1'b1;
        first = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_search_unit.sv
module tlb_search_unit
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_tag,
  input  logic [PID_W-1:0] cur_pid,
  input  logic             so_bit,
  input  logic             srch_en,
  input  logic [31:0]      srch_va,
  output logic             res_valid,
  output logic [31:0]      res_idx,
  output logic [3:0]       res_cr,
  output logic             wr_err
);
  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0][VA_W-1:0]  ent_epn;
  logic [ENTRIES-1:0][VA_W-1:0]  ent_mask;
  logic [ENTRIES-1:0][PID_W-1:0] ent_pid;
  logic [ENTRIES-1:0]            hit_vec;
  logic                          wr_reject;
  logic                          match_any;
  logic [IDX_W-1:0]              match_first;

  tlb_entry_bank #(.ENTRIES(ENTRIES), .PID_W(PID_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .cur_pid(cur_pid), .ent_valid(ent_valid),
    .ent_epn(ent_epn), .ent_mask(ent_mask), .ent_pid(ent_pid),
    .wr_reject(wr_reject)
  );

  tlb_match_vec #(.ENTRIES(ENTRIES), .PID_W(PID_W)) u_cmp (
    .ent_valid(ent_valid), .ent_epn(ent_epn), .ent_mask(ent_mask),
    .ent_pid(ent_pid), .va(srch_va), .pid(cur_pid), .hit_vec(hit_vec)
  );

  tlb_prio_enc #(.ENTRIES(ENTRIES)) u_enc (
    .req(hit_vec), .any(match_any), .first(match_first)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_idx   <= '1;
      res_cr    <= '0;
      wr_err    <= 1'b0;
    end else begin
      res_valid <= srch_en;
      wr_err    <= wr_reject;
      if (srch_en) begin
        res_idx <= match_any ? {{(32-IDX_W){1'b0}}, match_first} : '1;
        res_cr  <= {2'b00, match_any, so_bit};
      end
    end
  end
endmodule

// File: rtl/tlb_search_chk.sv
module tlb_search_chk #(
  parameter int ENTRIES = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_tag,
  input logic        so_bit,
  input logic        srch_en,
  input logic        match_any,
  input logic        res_valid,
  input logic [31:0] res_idx,
  input logic [3:0]  res_cr,
  input logic        wr_err
);
  assert_valid_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(srch_en));

  assert_err_only_after_le_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en && wr_tag[5]));

  assert_hit_bit_matches_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_cr[1] == (res_idx != 32'hFFFF_FFFF)));

  assert_so_copied_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_cr[0] == $past(so_bit)) && (res_cr[3:2] == 2'b00));

  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_idx == 32'hFFFF_FFFF || res_idx < 32'(ENTRIES)));

  assert_hit_from_compare_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_cr[1] == $past(match_any)));
endmodule

bind tlb_search_unit tlb_search_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tag(wr_tag),
  .so_bit(so_bit), .srch_en(srch_en), .match_any(match_any),
  .res_valid(res_valid), .res_idx(res_idx), .res_cr(res_cr), .wr_err(wr_err)
);

// File: tb/sim_tlb_search_unit.sv
`timescale 1ns/1ps
module sim_tlb_search_unit;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_tag = '0;
  logic [7:0]  cur_pid = '0;
  logic        so_bit = 1'b0;
  logic        srch_en = 1'b0;
  logic [31:0] srch_va = '0;
  logic        res_valid;
  logic [31:0] res_idx;
  logic [3:0]  res_cr;
  logic        wr_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model
  bit          m_v[N];
  logic [31:0] m_base[N];
  logic [2:0]  m_code[N];
  logic [7:0]  m_pid[N];

  always #4 clk = ~clk;

  tlb_search_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .cur_pid(cur_pid), .so_bit(so_bit), .srch_en(srch_en), .srch_va(srch_va),
    .res_valid(res_valid), .res_idx(res_idx), .res_cr(res_cr), .wr_err(wr_err)
  );

  function automatic logic [31:0] pg_bytes(input logic [2:0] c);
    logic [31:0] s;
    s = 32'd1024;
    for (int k = 0; k < int'(c); k++) s = s * 4;
    return s;
  endfunction

  function automatic logic [31:0] model_find(input logic [31:0] va, input logic [7:0] pid);
    for (int i = 0; i < N; i++) begin
      logic [31:0] sz;
      sz = pg_bytes(m_code[i]);
      if (m_v[i] && (m_pid[i] == 8'd0 || m_pid[i] == pid) &&
          (va / sz) == (m_base[i] / sz))
        return 32'(i);
    end
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mk_tag(input logic [31:0] va, input logic [2:0] code,
                                         input bit v, input bit le);
    return (va & 32'hFFFF_FC00) | (32'(code) << 7) | (32'(v) << 6) | (32'(le) << 5) | 32'h3;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [5:0] wi, input logic [31:0] wt,
                     input logic [7:0] pid, input bit so, input bit se,
                     input logic [31:0] va, input string tag);
    logic [31:0] e_idx;
    logic [3:0]  e_cr;
    wr_en = we; wr_idx = wi; wr_tag = wt; cur_pid = pid;
    so_bit = so; srch_en = se; srch_va = va;
    e_idx = model_find(va, pid);                 // R11: old contents
    e_cr  = {2'b00, (e_idx != 32'hFFFF_FFFF), so};
    @(posedge clk); #1;
    chk(res_valid == se, {tag, " R8 valid"}, 32'(res_valid), 32'(se));
    if (se) begin
      chk(res_idx == e_idx, {tag, " R5 R6 idx"}, res_idx, e_idx);
      chk(res_cr == e_cr, {tag, " R7 cr"}, 32'(res_cr), 32'(e_cr));
    end
    chk(wr_err == (we && wt[5]), {tag, " R9 err"}, 32'(wr_err), 32'(we && wt[5]));
    if (we && !wt[5]) begin
      m_v[wi] = wt[6]; m_code[wi] = wt[9:7]; m_pid[wi] = pid;
      m_base[wi] = wt & 32'hFFFF_FC00;
    end
    wr_en = 0; srch_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pool[4];
    int unsigned seed;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_base[i] = 0; m_code[i] = 0; m_pid[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(res_valid == 0 && wr_err == 0, "R1 outputs in reset", {res_valid, wr_err}, 0);
    rst_n = 1;
    #0;
    // R1: empty table misses, reported with both so values
    cyc(0, 0, 0, 8'd0, 0, 1, 32'h0000_0000, "R1 empty");
    cyc(0, 0, 0, 8'd2, 1, 1, 32'h1234_5678, "R1 R7 so");
    // R3 R5: global at 10, pid-3 entry at 5, same page
    cyc(1, 6'd10, mk_tag(32'h0001_0000, 0, 1, 0), 8'd0, 0, 0, 0, "R3 wr global");
    cyc(1, 6'd5,  mk_tag(32'h0001_0000, 0, 1, 0), 8'd3, 0, 0, 0, "R10 wr pid3");
    cyc(0, 0, 0, 8'd3, 0, 1, 32'h0001_0155, "R5 lowest");
    chk(res_idx == 32'd5, "R5 explicit", res_idx, 32'd5);
    cyc(0, 0, 0, 8'd4, 0, 1, 32'h0001_03FF, "R3 other pid");
    chk(res_idx == 32'd10, "R3 explicit", res_idx, 32'd10);
    // R2: invalid entry at 2 never wins
    cyc(1, 6'd2, mk_tag(32'h0001_0000, 0, 0, 0), 8'd0, 0, 0, 0, "R2 wr invalid");
    cyc(0, 0, 0, 8'd3, 0, 1, 32'h0001_0000, "R2 skip");
    chk(res_idx == 32'd5, "R2 explicit", res_idx, 32'd5);
    // R4: 16 KiB page and 16 MiB page
    cyc(1, 6'd20, mk_tag(32'h4000_0000, 3'd2, 1, 0), 8'd0, 0, 0, 0, "R4 wr 16k");
    cyc(0, 0, 0, 8'd1, 0, 1, 32'h4000_3C00, "R4 inside");
    chk(res_idx == 32'd20, "R4 explicit in", res_idx, 32'd20);
    cyc(0, 0, 0, 8'd1, 0, 1, 32'h4000_4000, "R4 outside");
    chk(res_idx == 32'hFFFF_FFFF, "R6 explicit miss", res_idx, 32'hFFFF_FFFF);
    cyc(1, 6'd30, mk_tag(32'h8123_4400, 3'd7, 1, 0), 8'd0, 0, 0, 0, "R4 wr 16m");
    cyc(0, 0, 0, 8'd1, 1, 1, 32'h81FF_FFFF, "R4 big page");
    chk(res_idx == 32'd30, "R4 explicit big", res_idx, 32'd30);
    // R9: little-endian write rejected, entry 0 untouched
    cyc(1, 6'd0, mk_tag(32'h4000_0000, 3'd2, 1, 1), 8'd0, 0, 0, 0, "R9 le write");
    cyc(0, 0, 0, 8'd1, 0, 1, 32'h4000_0000, "R9 unchanged");
    chk(res_idx == 32'd20, "R9 explicit", res_idx, 32'd20);
    // R10: pid latched at write
    cyc(1, 6'd40, mk_tag(32'h5000_0000, 0, 1, 0), 8'd7, 0, 0, 0, "R10 wr");
    cyc(0, 0, 0, 8'd7, 0, 1, 32'h5000_0000, "R10 same pid");
    cyc(0, 0, 0, 8'd8, 0, 1, 32'h5000_0000, "R10 later pid");
    chk(res_idx == 32'hFFFF_FFFF, "R10 explicit", res_idx, 32'hFFFF_FFFF);
    // R11: write and search together
    cyc(1, 6'd1, mk_tag(32'h5000_0000, 0, 1, 0), 8'd9, 0, 1, 32'h5000_0000, "R11 same cycle");
    chk(res_idx == 32'hFFFF_FFFF, "R11 explicit old", res_idx, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 8'd9, 0, 1, 32'h5000_0000, "R11 next cycle");
    chk(res_idx == 32'd1, "R11 explicit new", res_idx, 32'd1);
    // constrained random
    pool[0] = 32'h0001_0000; pool[1] = 32'h4000_0000; pool[2] = 32'h5000_0000; pool[3] = 32'h8100_0000;
    seed = 32'd1357;
    void'($urandom(seed));
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r, va, wt;
      r  = $urandom;
      wt = mk_tag(pool[r[1:0]] | ($urandom & 32'h000F_FC00), 3'($urandom % 8),
                  ($urandom % 8) != 0, ($urandom % 16) == 0);
      va = pool[r[3:2]] | ($urandom & 32'h001F_FFFF);
      cyc(r[4] | r[5], 6'($urandom % 64), wt, 8'($urandom % 4), r[6], r[7] | r[8], va, "rand");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule